// File: doc/BRIEF.md
# Full-Duplex Master/Slave Serial Port

This block moves data between a host and a clocked serial line in both directions at once. On the transmit side the host writes 16-bit half-words into a 16-entry queue; each half-word leaves as one 16-bit frame, most significant bit first. A frame-start strobe is high for the frame's first bit. On the receive side the line carries 8-bit frames, each marked by a receive frame-start input. The block packs each two bytes that arrive into one 16-bit entry of a receive queue. The host reads that queue. If an odd byte is left waiting, the host can issue a residual-pop command to force it into the queue.

The block runs as clock master, with the serial clock divided down from the system clock, or as slave, with the serial clock taken from an input and resynchronised. Transmit and receive each have an enable. A value written to an enable takes effect, and shows on its read-back output, only at the next serial clock rising edge. When both enables are clear the block reports itself idle. In master mode the serial clock pin toggles only while transmit is enabled.

Top module: `ssp_port`

## Requirements
- R1: The transmit queue holds 16 half-words. A write while it is full is dropped. `tx_full` is 1 while 16 entries are held and returns to 0 once a frame has taken an entry.
- R2: Each transmit frame is 16 bits, most significant bit first. `txfs_out` is 1 during the first bit only. Output bits change after a serial clock falling edge and are valid at the rising edge. Frames follow one another with no gap while the queue has data.
- R3: At a frame boundary with the transmit queue empty, no frame starts (`txfs_out` stays 0) and `tx_underflow` is set. `tx_underflow` clears on the next host transmit write.
- R4: A receive byte is 8 bits, MSB first, sampled on serial clock rising edges. A byte begins at the rising edge where `rxfs_in` is 1. Two consecutive bytes form one receive entry, with the first byte in bits 15:8 and the second in bits 7:0.
- R5: A `res_pop` pulse while one byte is waiting pushes the entry {8'h00, byte} into the receive queue. With no byte waiting, `res_pop` has no effect.
- R6: The receive queue holds 16 entries. A pair that completes while the queue is full is discarded and sets `rx_overflow`. The flag stays set, even across reads, until an `ovf_clr` pulse.
- R7: Enable values written with `ctl_we` appear on `tx_en_rb`/`rx_en_rb`, and take effect, only at the next serial clock rising edge.
- R8: After reset, `idle`=1, the read-backs are 0, both empty flags are 1, `tx_full`, `tx_underflow`, `rx_overflow` and `sclk_out` are 0. `idle` is 1 exactly when both applied enables are 0.
- R9: In master mode `sclk_out` toggles with a period of 2*SCLK_HALF system clocks while transmit is enabled. It stays low while transmit is disabled, even with receive enabled.
- R10: While receive is disabled, incoming bytes are ignored and no receive entry appears.
- R11: In slave mode the serial clock edges are taken from `sclk_in`.
- R12: `rx_rdata` shows the oldest receive entry while `rx_empty` is 0. An `rx_rd` pulse removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = generate serial clock, 0 = follow `sclk_in` |
| ctl_we | input | 1 | Write strobe for the enable values |
| ctl_tx_en | input | 1 | Requested transmit enable |
| ctl_rx_en | input | 1 | Requested receive enable |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | 16 | Half-word to transmit |
| rx_rd | input | 1 | Remove the oldest receive entry |
| rx_rdata | output | 16 | Oldest receive entry |
| res_pop | input | 1 | Push a waiting odd byte into the receive queue |
| ovf_clr | input | 1 | Clear the receive overflow flag |
| tx_en_rb | output | 1 | Applied transmit enable |
| rx_en_rb | output | 1 | Applied receive enable |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_underflow | output | 1 | A frame was due with nothing to send |
| rx_empty | output | 1 | Receive queue empty |
| rx_overflow | output | 1 | Sticky: a receive pair was lost |
| idle | output | 1 | Both applied enables clear |
| sclk_in | input | 1 | Serial clock in slave mode |
| sclk_out | output | 1 | Serial clock in master mode |
| txfs_out | output | 1 | Transmit frame start |
| txd_out | output | 1 | Transmit data |
| rxd_in | input | 1 | Receive data |
| rxfs_in | input | 1 | Receive frame start |

## Verification
The hardest condition to reach from the ports is a lost receive pair. The queue must already hold 16 entries, and then a full further pair must arrive, so that an entry exists only after its second byte lands. The bench reaches it in slave mode: it clocks 34 framed bytes into the port without reading, then drains the 16 survivors and checks that the flag outlives the reads. The residual path is reached with three bytes, which leaves one byte waiting. Enable lag is observed in slave mode, where the bench decides when the next serial rising edge occurs.

// File: rtl/ssp_pkg.sv
// Shared widths and types for the serial port.
// Assumes a 16-bit host word and 8-bit receive frames.
package ssp_pkg;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned BYTE_W = 8;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ssp_fifo.sv
// Synchronous first-word-fall-through queue.
// Assumes DEPTH is a power of two. A push while full is dropped, and a pop while empty is ignored.
module ssp_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // A full queue stays full until something is taken out.
    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
    // An empty queue stays empty until something is put in.
    p_empty_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);
endmodule

// File: rtl/ssp_clkgen.sv
// Serial clock source and enable application.
// In master mode the system clock is divided by 2*SCLK_HALF. The divider keeps running so that
// enable writes can be applied, but the pin only toggles while transmit is applied.
// In slave mode sclk_in is synchronised and its edges are detected.
// Enable writes wait in pending registers and are applied at the next serial rising edge.
module ssp_clkgen #(
    parameter int unsigned SCLK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic sclk_in,
    input  logic ctl_we,
    input  logic ctl_tx,
    input  logic ctl_rx,
    output logic rise_tick,
    output logic fall_tick,
    output logic sclk_out,
    output logic tx_en_q,
    output logic rx_en_q
);
    localparam int unsigned DW = (SCLK_HALF < 2) ? 1 : $clog2(SCLK_HALF);
    localparam logic [DW-1:0] DLAST = DW'(SCLK_HALF - 1);

    logic [DW-1:0] dcnt;
    logic          phase, wrap;
    logic          s_meta, s_sync, s_last;
    logic          pend_tx, pend_rx;
    logic          m_rise, m_fall, s_rise, s_fall;

    assign wrap      = (dcnt == DLAST);
    assign m_rise    = master && wrap && !phase;
    assign m_fall    = master && wrap && phase;
    assign s_rise    = !master && s_sync && !s_last;
    assign s_fall    = !master && !s_sync && s_last;
    assign rise_tick = m_rise || s_rise;
    assign fall_tick = m_fall || s_fall;

    // Free-running half-period divider for master mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !master) begin
            dcnt  <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            dcnt  <= '0;
            phase <= !phase;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

    // Two-stage synchroniser plus edge history for the slave clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_last <= 1'b0;
        end else begin
            s_meta <= sclk_in;
            s_sync <= s_meta;
            s_last <= s_sync;
        end
    end

    // Pending enables capture host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tx <= 1'b0;
            pend_rx <= 1'b0;
        end else if (ctl_we) begin
            pend_tx <= ctl_tx;
            pend_rx <= ctl_rx;
        end
    end

    // Applied enables follow the pending values at serial rising edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
        end else if (rise_tick) begin
            tx_en_q <= pend_tx;
            rx_en_q <= pend_rx;
        end
    end

    // Pin clock: high half only when transmit is being applied.
    always_ff @(posedge clk) begin
        if (!rst_n || !master) sclk_out <= 1'b0;
        else if (m_rise)       sclk_out <= pend_tx;
        else if (m_fall)       sclk_out <= 1'b0;
    end

    // Applied enables move only on a serial rising edge.
    p_enable_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_tick |=> ($stable(tx_en_q) && $stable(rx_en_q)));
    // No falling and rising event in the same system cycle.
    p_tick_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick && fall_tick));
endmodule

// File: rtl/ssp_tx.sv
// Transmit serialiser: 16-bit frames, MSB first, frame strobe on the first bit.
// All updates happen on serial falling events. With the queue empty at a boundary it raises
// a one-cycle underflow pulse and keeps the line quiet. Assumes the queue gives its head with no latency.
module ssp_tx
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  fall_tick,
    input  logic  q_empty,
    input  half_t q_data,
    output logic  q_pop,
    output logic  txd,
    output logic  fs,
    output logic  urun
);
    localparam int unsigned LW = $clog2(HALF_W);
    localparam logic [LW-1:0] LFULL = LW'(HALF_W - 1);

    half_t         shreg;
    logic [LW-1:0] left;
    logic          boundary;

    assign boundary = en && fall_tick && (left == '0);
    assign q_pop    = boundary && !q_empty;
    assign urun     = boundary && q_empty;

    // Shifter, bit counter and line outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            shreg <= '0;
            left  <= '0;
            txd   <= 1'b0;
            fs    <= 1'b0;
        end else if (fall_tick) begin
            if (left == '0) begin
                if (!q_empty) begin
                    shreg <= q_data;
                    txd   <= q_data[HALF_W-1];
                    fs    <= 1'b1;
                    left  <= LFULL;
                end else begin
                    txd <= 1'b0;
                    fs  <= 1'b0;
                end
            end else begin
                shreg <= {shreg[HALF_W-2:0], 1'b0};
                txd   <= shreg[HALF_W-2];
                fs    <= 1'b0;
                left  <= left - 1'b1;
            end
        end
    end

    // A frame strobe appears only for a word taken from the queue.
    p_frame_from_queue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs) |-> $past(q_pop));
endmodule

// File: rtl/ssp_rx.sv
// Receive deserialiser and byte pairer.
// Bytes are sampled MSB first on serial rising events. A frame input restarts the byte.
// Two bytes form one half-word, first byte high. A residual command flushes a lone byte,
// zero-extended. The pending byte is dropped whenever a push is requested, even if the queue refuses it.
module ssp_rx
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  rise_tick,
    input  logic  rxd,
    input  logic  fsync,
    input  logic  res_pop,
    output logic  push_req,
    output half_t push_data
);
    localparam int unsigned CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] CLAST = CW'(BYTE_W - 1);

    logic [BYTE_W-2:0] sh;
    logic [CW-1:0]     cnt;
    byte_t             hold, new_byte;
    logic              pending, byte_done;

    assign new_byte  = {sh, rxd};
    assign byte_done = en && rise_tick && !fsync && (cnt == CLAST);

    // Request a push for a completed pair or a flushed residual byte.
    always_comb begin
        push_req  = 1'b0;
        push_data = '0;
        if (byte_done) begin
            push_req  = pending;
            push_data = {hold, new_byte};
        end else if (res_pop && pending) begin
            push_req  = 1'b1;
            push_data = {{(HALF_W-BYTE_W){1'b0}}, hold};
        end
    end

    // Bit collection.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh  <= '0;
            cnt <= '0;
        end else if (rise_tick) begin
            if (fsync) begin
                sh  <= {{(BYTE_W-2){1'b0}}, rxd};
                cnt <= CW'(1);
            end else if (cnt != '0) begin
                sh  <= {sh[BYTE_W-3:0], rxd};
                cnt <= (cnt == CLAST) ? '0 : cnt + 1'b1;
            end
        end
    end

    // Odd-byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold    <= '0;
            pending <= 1'b0;
        end else if (byte_done && !pending) begin
            hold    <= new_byte;
            pending <= 1'b1;
        end else if (push_req) begin
            pending <= 1'b0;
        end
    end

    // After any push the holding register is empty, so pushes never come back to back.
    p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> !push_req);
endmodule

// File: rtl/ssp_port.sv
// Top of the master/slave serial port.
// Wires the clock source, the two queues and the two serialisers, and holds the sticky flags.
// Assumes host strobes are single-cycle and synchronous to clk.
module ssp_port
    import ssp_pkg::*;
#(
    parameter int unsigned TX_DEPTH  = 16,
    parameter int unsigned RX_DEPTH  = 16,
    parameter int unsigned SCLK_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_master,
    input  logic        ctl_we,
    input  logic        ctl_tx_en,
    input  logic        ctl_rx_en,
    input  logic        tx_wr,
    input  logic [15:0] tx_wdata,
    input  logic        rx_rd,
    output logic [15:0] rx_rdata,
    input  logic        res_pop,
    input  logic        ovf_clr,
    output logic        tx_en_rb,
    output logic        rx_en_rb,
    output logic        tx_full,
    output logic        tx_empty,
    output logic        tx_underflow,
    output logic        rx_empty,
    output logic        rx_overflow,
    output logic        idle,
    input  logic        sclk_in,
    output logic        sclk_out,
    output logic        txfs_out,
    output logic        txd_out,
    input  logic        rxd_in,
    input  logic        rxfs_in
);
    logic  rise_tick, fall_tick;
    logic  tq_pop, tq_empty, urun_pulse;
    half_t tq_data;
    logic  rq_push_req, rq_full;
    half_t rq_push_data;

    ssp_clkgen #(.SCLK_HALF(SCLK_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .master(cfg_master), .sclk_in(sclk_in),
        .ctl_we(ctl_we), .ctl_tx(ctl_tx_en), .ctl_rx(ctl_rx_en),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .sclk_out(sclk_out),
        .tx_en_q(tx_en_rb), .rx_en_q(rx_en_rb)
    );

    ssp_fifo #(.W(HALF_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_wdata),
        .pop(tq_pop), .rdata(tq_data), .full(tx_full), .empty(tq_empty)
    );

    ssp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en_rb), .fall_tick(fall_tick),
        .q_empty(tq_empty), .q_data(tq_data), .q_pop(tq_pop),
        .txd(txd_out), .fs(txfs_out), .urun(urun_pulse)
    );

    ssp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en_rb), .rise_tick(rise_tick),
        .rxd(rxd_in), .fsync(rxfs_in), .res_pop(res_pop),
        .push_req(rq_push_req), .push_data(rq_push_data)
    );

    ssp_fifo #(.W(HALF_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rq_push_req), .wdata(rq_push_data),
        .pop(rx_rd), .rdata(rx_rdata), .full(rq_full), .empty(rx_empty)
    );

    assign tx_empty = tq_empty;
    assign idle     = !tx_en_rb && !rx_en_rb;

    // Sticky underflow: a host write clears it, and the write wins a same-cycle tie.
    always_ff @(posedge clk) begin
        if (!rst_n)          tx_underflow <= 1'b0;
        else if (tx_wr)      tx_underflow <= 1'b0;
        else if (urun_pulse) tx_underflow <= 1'b1;
    end

    // Sticky overflow: set by a refused pair, cleared only by the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rx_overflow <= 1'b0;
        else if (rq_push_req && rq_full)   rx_overflow <= 1'b1;
        else if (ovf_clr)                  rx_overflow <= 1'b0;
    end

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_overflow) && !$past(ovf_clr)) |-> rx_overflow);
    p_clock_needs_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |-> tx_en_rb);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!sclk_out && !txfs_out));
    p_no_strobe_when_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tq_empty) && $past(fall_tick)) |-> !txfs_out);
endmodule

// File: tb/ssp_port_tb.sv
`timescale 1ns/1ps
module ssp_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1;
    logic        ctl_we = 1'b0, ctl_tx_en = 1'b0, ctl_rx_en = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_rdata;
    logic        res_pop = 1'b0, ovf_clr = 1'b0;
    logic        tx_en_rb, rx_en_rb, tx_full, tx_empty, tx_underflow;
    logic        rx_empty, rx_overflow, idle;
    logic        sclk_in = 1'b0;
    logic        sclk_out, txfs_out, txd_out;
    logic        rxd_in = 1'b0, rxfs_in = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int edges = 0;
    time t_first = 0;
    logic [15:0] exp_tx[$];
    logic [15:0] exp_rx[$];

    always #5 clk = !clk;

    ssp_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .ctl_we(ctl_we),
        .ctl_tx_en(ctl_tx_en), .ctl_rx_en(ctl_rx_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .res_pop(res_pop), .ovf_clr(ovf_clr),
        .tx_en_rb(tx_en_rb), .rx_en_rb(rx_en_rb), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_underflow(tx_underflow), .rx_empty(rx_empty), .rx_overflow(rx_overflow),
        .idle(idle), .sclk_in(sclk_in), .sclk_out(sclk_out), .txfs_out(txfs_out),
        .txd_out(txd_out), .rxd_in(rxd_in), .rxfs_in(rxfs_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic set_en(input logic t, input logic r);
        @(negedge clk); ctl_we = 1'b1; ctl_tx_en = t; ctl_rx_en = r;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic write_tx(input logic [15:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic slave_bit(input logic b, input logic f);
        rxd_in = b; rxfs_in = f;
        repeat (5) @(negedge clk);
        sclk_in = 1'b1;
        repeat (5) @(negedge clk);
        sclk_in = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) slave_bit(b[i], i == 7);
        rxfs_in = 1'b0;
    endtask

    task automatic pulse_res();
        @(negedge clk); res_pop = 1'b1;
        @(negedge clk); res_pop = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Scoreboard reader for the receive queue (R12).
    task automatic drain(input string tag);
        @(negedge clk);
        while (!rx_empty) begin
            if (exp_rx.size() == 0) chk(0, {tag, " R12 extra entry"}, rx_rdata, 0);
            else begin
                logic [15:0] e;
                e = exp_rx.pop_front();
                chk(rx_rdata == e, tag, rx_rdata, e);
            end
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
            @(negedge clk);
        end
        chk(exp_rx.size() == 0, {tag, " R12 missing entries"}, exp_rx.size(), 0);
        exp_rx.delete();
    endtask

    // Transmit monitor: rebuilds frames at sclk_out rising edges (R2) and checks the period (R9).
    initial begin
        logic [15:0] sh;
        int nb;
        nb = 0; sh = '0;
        forever begin
            @(posedge sclk_out);
            #1;
            edges++;
            if (edges == 1) t_first = $time;
            if (edges == 2) chk(($time - t_first) == 80, "R9 sclk period", 32'($time - t_first), 80);
            if (txfs_out) begin
                sh = {15'b0, txd_out};
                nb = 1;
            end else if (nb > 0 && nb < 16) begin
                sh = {sh[14:0], txd_out};
                nb++;
            end
            if (nb == 16) begin
                nb = 0;
                if (exp_tx.size() == 0) chk(0, "R3 unexpected frame", sh, 0);
                else begin
                    logic [15:0] e;
                    e = exp_tx.pop_front();
                    chk(sh == e, "R2 frame data", sh, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int e0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(idle == 1 && tx_en_rb == 0 && rx_en_rb == 0, "R8 reset idle/enables", {idle, tx_en_rb, rx_en_rb}, 3'b100);
        chk(tx_empty && rx_empty && !tx_full, "R8 reset queue flags", {tx_empty, rx_empty, tx_full}, 3'b110);
        chk(!tx_underflow && !rx_overflow && !sclk_out, "R8 reset sticky/sclk", {tx_underflow, rx_overflow, sclk_out}, 0);

        // R1 fill transmit queue while transmit is off (master mode)
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            w = (i == 0) ? 16'h8000 : (i == 1) ? 16'h0001 : (i == 2) ? 16'hFFFF :
                (i == 3) ? 16'h0000 : 16'((i * 16'h1357) ^ 16'hA5C3);
            write_tx(w);
            exp_tx.push_back(w);
        end
        chk(tx_full == 1, "R1 full after 16 writes", tx_full, 1);
        write_tx(16'hDEAD);   // dropped
        chk(tx_full == 1, "R1 still full after dropped write", tx_full, 1);

        // R9 receive-only master: clock must stay low
        set_en(1'b0, 1'b1);
        repeat (40) @(negedge clk);
        chk(rx_en_rb == 1 && idle == 0, "R8 rx-only not idle", {rx_en_rb, idle}, 2'b10);
        chk(edges == 0, "R9 no clock with tx off", edges, 0);

        // R2 transmit all 16 words
        set_en(1'b1, 1'b0);
        repeat (40) @(negedge clk);
        chk(tx_full == 0, "R1 full clears after a frame", tx_full, 0);
        for (int k = 0; k < 6000 && exp_tx.size() != 0; k++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(exp_tx.size() == 0, "R2 all frames seen", exp_tx.size(), 0);
        chk(tx_underflow == 1, "R3 underflow when queue empty", tx_underflow, 1);
        chk(txfs_out == 0, "R3 no strobe when empty", txfs_out, 0);
        exp_tx.push_back(16'h5A3C);
        write_tx(16'h5A3C);
        @(negedge clk);
        chk(tx_underflow == 0, "R3 underflow cleared by write", tx_underflow, 0);
        for (int k = 0; k < 2000 && exp_tx.size() != 0; k++) @(negedge clk);
        chk(exp_tx.size() == 0, "R2 frame after underflow", exp_tx.size(), 0);

        // R9 disabling transmit stops the clock
        set_en(1'b0, 1'b0);
        repeat (20) @(negedge clk);
        e0 = edges;
        repeat (100) @(negedge clk);
        chk(edges == e0, "R9 clock stopped", edges, e0);
        chk(idle == 1, "R8 idle after disable", idle, 1);

        // Slave mode
        cfg_master = 1'b0;
        repeat (4) @(negedge clk);
        // R10 receive disabled ignores bytes
        send_byte(8'h11);
        send_byte(8'h22);
        repeat (4) @(negedge clk);
        chk(rx_empty == 1, "R10 bytes ignored", rx_empty, 1);

        // R7 enable lag
        set_en(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk(rx_en_rb == 0, "R7 enable not yet applied", rx_en_rb, 0);
        slave_bit(1'b0, 1'b0);
        chk(rx_en_rb == 1, "R7 applied at serial rise (R11)", rx_en_rb, 1);
        pulse_res();
        chk(rx_empty == 1, "R10 nothing pending from disabled period", rx_empty, 1);

        // R4 byte pairing
        send_byte(8'hA1);
        send_byte(8'hB2);
        exp_rx.push_back(16'hA1B2);
        drain("R4 pair");

        // R5 odd byte and residual pop
        send_byte(8'hC3);
        send_byte(8'hD4);
        send_byte(8'hE5);
        exp_rx.push_back(16'hC3D4);
        drain("R4 pair before residual");
        pulse_res();
        exp_rx.push_back(16'h00E5);
        drain("R5 residual");
        pulse_res();
        chk(rx_empty == 1, "R5 pop with nothing pending", rx_empty, 1);

        // R6 overflow
        for (int k = 0; k < 17; k++) begin
            logic [7:0] a, b;
            a = 8'(k * 7 + 3);
            b = 8'(~(k * 13));
            send_byte(a);
            send_byte(b);
            if (k < 16) exp_rx.push_back({a, b});
            if (k == 15) chk(rx_overflow == 0, "R6 no overflow at 16", rx_overflow, 0);
        end
        repeat (3) @(negedge clk);
        chk(rx_overflow == 1, "R6 overflow set", rx_overflow, 1);
        drain("R6 survivors");
        chk(rx_overflow == 1, "R6 sticky across reads", rx_overflow, 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        @(negedge clk);
        chk(rx_overflow == 0, "R6 cleared by command", rx_overflow, 0);

        summary();
        $finish;
    end
endmodule